// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block sits in the command path of a single-data-rate SDRAM controller. It takes READ and WRITE requests, each with a bank and a column, and turns them into a per-cycle command stream of READ, WRITE or NOP. It also drives the data mask and the controller's DQ output-enable. Its job is the change from reading to writing. It tracks how long read data will keep arriving on the shared DQ bus. When a WRITE is requested, it picks the earliest cycle in which that WRITE can be issued without bus contention.

A WRITE can be issued in one of two ways. It can wait until the last read beat has passed. Or it can cut the read burst short by raising the mask two cycles ahead, because the mask acts on read output data two cycles late and on write input data at once. An optional extra NOP keeps one idle cycle on the bus between the last driven read beat and the WRITE. This is for systems whose data driver may turn on before the memory releases the pins. Requests use a valid/ready handshake, and ready stays low while a WRITE is being sequenced or its burst is being driven.

Top module: `sdr_turnaround`

## Requirements
- R1: After reset, cmd_out is NOP (2'b00), dqm_out is 0, dq_oe is 0 and req_ready is 1.
- R2: Commands use the encoding NOP=2'b00, READ=2'b01, WRITE=2'b10, and 2'b11 never appears. A READ accepted in cycle a appears as READ with its bank and column in cycle a+1. Its data occupies the bus from cycle a+1+CAS_LAT for as many beats as the burst length, where cfg_burst 0/1/2/3 selects 1/2/4/8 beats.
- R3: A WRITE accepted in cycle a while no read data remains at or after cycle a is issued in cycle a+1, with its own bank and column. The bank can be any bank, whatever the bank of the preceding READ.
- R4: Let L be the last read data cycle still pending when a WRITE is accepted in cycle a. If L ≤ a+2, or the burst length is 1, the WRITE is issued in cycle L+1 (L+2 with cfg_extra_nop). Every cycle between acceptance and the WRITE is a NOP with dqm_out low.
- R5: If the burst length is above 1 and L > a+2, the read is truncated. The WRITE is issued in cycle a+3 (a+4 with cfg_extra_nop), and dqm_out is high in every cycle from a+1 up to the cycle before the WRITE.
- R6: dqm_out is low in the WRITE cycle and in every cycle in which dq_oe is high.
- R7: dq_oe rises only in a WRITE cycle and stays high for exactly the burst length in beats.
- R8: req_ready is low from the cycle after a delayed WRITE is accepted until its issue cycle. During a write burst it is low on every beat except the last.
- R9: With a burst length of 1, dqm_out never rises.
- R10: dq_oe is never high in a cycle in which the memory still drives unmasked read data. With cfg_extra_nop set, the cycle before a WRITE carries no driven read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = WRITE request, 0 = READ request |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column |
| cfg_burst | input | 2 | Burst length code: 0/1/2/3 = 1/2/4/8 beats |
| cfg_extra_nop | input | 1 | Insert one idle bus cycle before a WRITE that follows read data |
| req_ready | output | 1 | Request is accepted this cycle when valid is also high |
| cmd_out | output | 2 | Command this cycle: 00 NOP, 01 READ, 10 WRITE |
| bank_out | output | BANK_W | Bank of the current command |
| col_out | output | COL_W | Column of the current command |
| dqm_out | output | 1 | Data mask |
| dq_oe | output | 1 | Controller DQ output-enable (write data beats) |

## Verification
A read-tail counter that is too short lets a WRITE go out one or more cycles early, and the bus model catches dq_oe overlapping a driven read beat in the WRITE cycle itself. A tail that is too long shows up as a WRITE one cycle late, or as an unneeded truncation with the mask raised. Both are seen on the cycle the bench predicted for the WRITE, at most five cycles after acceptance. A scheduler that loses its mask state leaves the beat two cycles later unmasked, so the contention check fires within three cycles. An output-enable count that is off shows up on the first or last beat of the write burst.

// File: rtl/sdr_ta_pkg.sv
package sdr_ta_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10
  } sdr_cmd_e;

  // Beats in one burst for a 2-bit length code.
  function automatic int unsigned burst_beats(input logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // Truncation is worth it only when data runs past acceptance + 2.
  function automatic logic tail_needs_mask(input int unsigned tail,
                                           input int unsigned beats);
    return (beats > 1) && (tail > 3);
  endfunction

  // Cycles from acceptance to WRITE issue, given the pending read tail
  // (number of data cycles left, counting the accept cycle).
  function automatic int unsigned tail_to_delay(input int unsigned tail,
                                                input int unsigned beats,
                                                input logic        gap);
    int unsigned g;
    g = gap ? 32'd1 : 32'd0;
    if (tail == 0) return 32'd1;
    if (tail_needs_mask(tail, beats)) return 32'd3 + g;
    return tail + g;
  endfunction

endpackage

// File: rtl/sdr_ta_rdtrack.sv
module sdr_ta_rdtrack #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic             wr_issue,
  input  logic [CNT_W-1:0] rd_len,
  output logic [CNT_W-1:0] tail,
  output logic             rd_busy
);
  logic [CNT_W-1:0] tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  tail_q <= '0;
    else if (rd_fire)            tail_q <= rd_len;
    else if (wr_issue)           tail_q <= '0;
    else if (tail_q != '0)       tail_q <= tail_q - 1'b1;
  end

  assign tail    = tail_q;
  assign rd_busy = (tail_q != '0);
endmodule

// File: rtl/sdr_ta_wrsched.sv
module sdr_ta_wrsched #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [CNT_W-1:0] delay,
  input  logic             mask_req,
  output logic             pend,
  output logic             wr_issue,
  output logic             dqm_next
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             mask_q;
  logic             direct;

  assign direct   = wr_fire && (delay <= CNT_W'(1));
  assign wr_issue = direct || (pend_q && (cnt_q == '0));
  assign dqm_next = (wr_fire && !direct) ? mask_req :
                    (pend_q && (cnt_q != '0)) ? mask_q : 1'b0;
  assign pend     = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      mask_q <= 1'b0;
    end else if (wr_fire && !direct) begin
      pend_q <= 1'b1;
      cnt_q  <= delay - CNT_W'(2);
      mask_q <= mask_req;
    end else if (pend_q) begin
      if (cnt_q == '0) pend_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sdr_ta_oewin.sv
module sdr_ta_oewin #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_issue,
  input  logic [CNT_W-1:0] beats,
  output logic             oe,
  output logic             near_idle
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              left_q <= '0;
    else if (wr_issue)       left_q <= beats;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign oe        = (left_q != '0);
  assign near_idle = (left_q <= CNT_W'(1));
endmodule

// File: rtl/sdr_turnaround.sv
module sdr_turnaround
  import sdr_ta_pkg::*;
#(
  parameter int CAS_LAT = 3,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        cfg_burst,
  input  logic              cfg_extra_nop,
  output logic              req_ready,
  output logic [1:0]        cmd_out,
  output logic [BANK_W-1:0] bank_out,
  output logic [COL_W-1:0]  col_out,
  output logic              dqm_out,
  output logic              dq_oe
);
  localparam int MAX_BEATS = 8;
  localparam int CNT_W     = $clog2(CAS_LAT + MAX_BEATS + 4);

  // Named internal events
  logic             accept, rd_fire, wr_fire;
  logic [CNT_W-1:0] beats, rd_len, rd_tail, wr_delay;
  logic             rd_busy, wr_mask, wr_pend, wr_issue, dqm_next;
  logic             oe_near_idle;

  sdr_cmd_e          cmd_q;
  logic [BANK_W-1:0] bank_q, wbank_q;
  logic [COL_W-1:0]  col_q, wcol_q;
  logic              dqm_q;

  assign accept   = req_valid && req_ready;
  assign rd_fire  = accept && !req_write;
  assign wr_fire  = accept && req_write;
  assign beats    = CNT_W'(burst_beats(cfg_burst));
  assign rd_len   = CNT_W'(CAS_LAT) + beats;
  assign wr_delay = CNT_W'(tail_to_delay(32'(rd_tail), burst_beats(cfg_burst), cfg_extra_nop));
  assign wr_mask  = tail_needs_mask(32'(rd_tail), burst_beats(cfg_burst));

  sdr_ta_rdtrack #(.CNT_W(CNT_W)) u_rdtrack (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .wr_issue(wr_issue),
    .rd_len(rd_len), .tail(rd_tail), .rd_busy(rd_busy)
  );

  sdr_ta_wrsched #(.CNT_W(CNT_W)) u_wrsched (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .delay(wr_delay),
    .mask_req(wr_mask), .pend(wr_pend), .wr_issue(wr_issue), .dqm_next(dqm_next)
  );

  sdr_ta_oewin #(.CNT_W(CNT_W)) u_oewin (
    .clk(clk), .rst_n(rst_n), .wr_issue(wr_issue), .beats(beats),
    .oe(dq_oe), .near_idle(oe_near_idle)
  );

  assign req_ready = !wr_pend && oe_near_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= CMD_NOP;
      bank_q  <= '0;
      col_q   <= '0;
      wbank_q <= '0;
      wcol_q  <= '0;
      dqm_q   <= 1'b0;
    end else begin
      dqm_q <= dqm_next;
      if (wr_fire) begin
        wbank_q <= req_bank;
        wcol_q  <= req_col;
      end
      if (rd_fire) begin
        cmd_q  <= CMD_READ;
        bank_q <= req_bank;
        col_q  <= req_col;
      end else if (wr_issue) begin
        cmd_q  <= CMD_WRITE;
        bank_q <= wr_fire ? req_bank : wbank_q;
        col_q  <= wr_fire ? req_col  : wcol_q;
      end else begin
        cmd_q  <= CMD_NOP;
      end
    end
  end

  assign cmd_out  = cmd_q;
  assign bank_out = bank_q;
  assign col_out  = col_q;
  assign dqm_out  = dqm_q;
endmodule

// File: rtl/sdr_turnaround_chk.sv
module sdr_turnaround_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [1:0]       cmd_out,
  input logic             dqm_out,
  input logic             dq_oe,
  input logic [1:0]       cfg_burst,
  input logic [CNT_W-1:0] tail,
  input logic             pend
);
  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_out != 2'b11); // R2

  AST_OE_STARTS_AT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (cmd_out == 2'b10)); // R7

  AST_DQM_LOW_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !dqm_out); // R6

  AST_MASK_BEFORE_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_out == 2'b10) && ($past(tail) > 1)) |-> ($past(dqm_out) && $past(dqm_out, 2))); // R5

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !req_ready); // R8

  AST_BL1_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_burst == 2'b00) && $stable(cfg_burst) && $past(cfg_burst, 2) == 2'b00
     && $past(cfg_burst, 3) == 2'b00) |-> !dqm_out); // R9
endmodule

bind sdr_turnaround sdr_turnaround_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cmd_out(cmd_out),
  .dqm_out(dqm_out), .dq_oe(dq_oe), .cfg_burst(cfg_burst),
  .tail(rd_tail), .pend(wr_pend)
);

// File: tb/sdr_turnaround_bench.sv
`timescale 1ns/1ps
module sdr_turnaround_bench;
  localparam int CL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [8:0] req_col = '0;
  logic [1:0] cfg_burst = 2'd2;
  logic       cfg_extra_nop = 1'b0;
  logic       req_ready, dqm_out, dq_oe;
  logic [1:0] cmd_out, bank_out;
  logic [8:0] col_out;

  sdr_turnaround #(.CAS_LAT(CL), .BANK_W(2), .COL_W(9)) u_sdr_turnaround (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_col(req_col), .cfg_burst(cfg_burst),
    .cfg_extra_nop(cfg_extra_nop), .req_ready(req_ready), .cmd_out(cmd_out),
    .bank_out(bank_out), .col_out(col_out), .dqm_out(dqm_out), .dq_oe(dq_oe)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0, fails = 0;
  bit  done = 0, mon_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Bus model: which future cycles carry read data, and the mask history
  bit data_at [32];
  bit dqm_at  [32];
  bit last_drive = 0;

  // Expectations
  bit         exp_rd_on = 0, exp_wr_on = 0, oe_on = 0, exp_mask = 0;
  int         exp_rd_c, exp_a, exp_w, oe_to;
  logic [1:0] exp_bk, exp_rbk;
  logic [8:0] exp_cl, exp_rcl;

  function automatic int beats_of(input logic [1:0] code);
    case (code) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 8; endcase
  endfunction

  function automatic int write_cycle(input int a, input int lastk, input int bl, input bit gap);
    int l, w;
    if (lastk < 0) return a + 1;
    l = a + lastk;
    if (bl > 1 && l > a + 2) return a + 3 + (gap ? 1 : 0);
    w = l + 1 + (gap ? 1 : 0);
    return (w < a + 1) ? a + 1 : w;
  endfunction

  always @(negedge clk) begin
    if (mon_on && !done) begin
      int  c, bl;
      bit  drive;
      c  = cyc;
      bl = beats_of(cfg_burst);
      dqm_at[c % 32] = dqm_out;
      chk(cmd_out != 2'b11, "R2 legal command", cmd_out, 0);
      if (cmd_out == 2'b01)
        for (int i = 0; i < bl; i++) data_at[(c + CL + i) % 32] = 1;
      if (cmd_out == 2'b10 && dqm_at[(c + 31) % 32])
        for (int i = 0; i < 16; i++) data_at[(c + i) % 32] = 0;
      drive = data_at[c % 32] && !dqm_at[(c + 30) % 32];
      chk(!(drive && dq_oe), "R10 no DQ contention", dq_oe, 0);
      if (dq_oe && cfg_extra_nop && cmd_out == 2'b10)
        chk(!last_drive, "R10 idle cycle before write", last_drive, 0);
      if (dq_oe) chk(!dqm_out, "R6 dqm low on write data", dqm_out, 0);
      if (bl == 1) chk(!dqm_out, "R9 no mask with single beat", dqm_out, 0);
      // expected read issue
      if (exp_rd_on && c == exp_rd_c) begin
        chk(cmd_out == 2'b01, "R2 read issue", cmd_out, 1);
        chk(bank_out == exp_rbk && col_out == exp_rcl, "R2 read address",
            {bank_out, col_out}, {exp_rbk, exp_rcl});
        exp_rd_on = 0;
      end
      // expected write sequence
      if (exp_wr_on && c > exp_a && c < exp_w) begin
        chk(cmd_out == 2'b00, exp_mask ? "R5 nop before write" : "R4 nop before write", cmd_out, 0);
        chk(dqm_out == exp_mask, exp_mask ? "R5 mask held" : "R4 no mask", dqm_out, exp_mask);
        chk(!req_ready, "R8 ready low while sequencing", req_ready, 0);
      end else if (exp_wr_on && c == exp_w) begin
        chk(cmd_out == 2'b10, (exp_w == exp_a + 1) ? "R3 write issue" :
            exp_mask ? "R5 write issue" : "R4 write issue", cmd_out, 2);
        chk(bank_out == exp_bk && col_out == exp_cl, "R3 write address",
            {bank_out, col_out}, {exp_bk, exp_cl});
        chk(!dqm_out, "R6 dqm low at write", dqm_out, 0);
        exp_wr_on = 0;
        oe_on = 1;
        oe_to = c + bl - 1;
      end
      if (oe_on) begin
        chk(dq_oe == (c <= oe_to), "R7 output enable window", dq_oe, c <= oe_to);
        if (c <= oe_to) chk(req_ready == (c == oe_to), "R8 ready during burst", req_ready, c == oe_to);
        if (c > oe_to) oe_on = 0;
      end
      last_drive = drive;
      data_at[(c + 20) % 32] = 0;
    end
  end

  task automatic send(input bit wr, input logic [1:0] bk, input logic [8:0] cl);
    int a, lastk;
    req_valid = 1; req_write = wr; req_bank = bk; req_col = cl;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    a = cyc;
    if (wr) begin
      lastk = -1;
      for (int k = 0; k < 20; k++) if (data_at[(a + k) % 32]) lastk = k;
      exp_a = a;
      exp_w = write_cycle(a, lastk, beats_of(cfg_burst), cfg_extra_nop);
      exp_mask = (beats_of(cfg_burst) > 1) && (lastk > 2);
      exp_bk = bk; exp_cl = cl; exp_wr_on = 1;
    end else begin
      exp_rd_c = a + 1; exp_rbk = bk; exp_rcl = cl; exp_rd_on = 1;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired cyc=%0d actual=0 expected=1", cyc);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_out == 2'b00, "R1 reset cmd", cmd_out, 0);
    chk(!dqm_out, "R1 reset dqm", dqm_out, 0);
    chk(!dq_oe, "R1 reset oe", dq_oe, 0);
    chk(req_ready, "R1 reset ready", req_ready, 1);
    mon_on = 1;

    // Directed: truncation, BL4 (R5), then with extra NOP
    cfg_burst = 2'd2; cfg_extra_nop = 0;
    send(0, 2'd1, 9'd10); send(1, 2'd3, 9'd20); settle();
    cfg_extra_nop = 1;
    send(0, 2'd0, 9'd30); send(1, 2'd2, 9'd40); settle();
    // Directed: write with nothing pending (R3)
    send(1, 2'd1, 9'd50); settle();
    // Directed: wait for short tail (R4)
    cfg_burst = 2'd1; cfg_extra_nop = 0;
    send(0, 2'd2, 9'd60); repeat (3) @(negedge clk); send(1, 2'd0, 9'd70); settle();
    // Directed: single beat never masks (R9)
    cfg_burst = 2'd0; cfg_extra_nop = 1;
    send(0, 2'd3, 9'd80); send(1, 2'd3, 9'd90); settle();

    // Constrained random over all configurations
    for (int p = 0; p < 8; p++) begin
      cfg_burst = p[1:0]; cfg_extra_nop = p[2];
      for (int n = 0; n < 40; n++) begin
        send(1'($urandom % 2), 2'($urandom), 9'($urandom));
        repeat ($urandom % 4) @(negedge clk);
      end
      settle();
    end
    finish_run();
  end
endmodule